// File: doc/BRIEF.md
# Byte-Multiplexed Flash Access Sequencer

This block lets on-chip logic read and write an external flash or EPROM that shares one 8-bit bus between address and data. Each host request carries a 20-bit address, a read/write flag and write data, and is taken through a valid/ready handshake. The address goes out as three bytes, lowest byte first. Each byte is marked by active-low strobes that clock latch banks on the board. After the address, the block runs a data phase. A read uses the output-enable pin and a write uses the write-enable pin, and chip enable stays low for the whole access.

Each address byte is held on the bus for a setup window, a strobe window and a hold window. The lengths of these windows are parameters. In the third byte, both strobes pulse together, so a board decoder can clock the latch for address bits [19:16]. Before a read the bus is released for one turnaround cycle. The memory's byte is then sampled in the last cycle of a programmable wait. A read completes with a one-cycle response pulse that carries the captured byte, and the next request can be accepted in that same cycle.

Top module: `flash_mux_seq`

## Requirements
- R1: Out of reset and while idle, `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_as0_n` and `mem_as1_n` are all 1, `bus_oe` is 0 and `req_ready` is 1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the access ends, and `req_valid` has no effect during that time.
- R3: The address phase is three slots of SETUP_CYC+STROBE_CYC+HOLD_CYC cycles each, with `bus_oe`=1 throughout. The slots carry `bus_out` = addr[7:0], then addr[15:8], then {4'b0000, addr[19:16]}, and the value is constant within a slot.
- R4: In each slot the strobes are low for STROBE_CYC cycles, starting after SETUP_CYC cycles. Slot 0 lowers only `mem_as0_n`, slot 1 lowers only `mem_as1_n`, and slot 2 lowers both. A board latch clocked on the rising edge of each strobe pattern therefore ends the access holding the full request address.
- R5: `mem_ce_n` is 0 from the first cycle after acceptance through the last cycle of the access, and it is 1 in the cycle after that.
- R6: A read has one turnaround cycle after the address phase with `bus_oe`=0 and `mem_oe_n`=1. Then `mem_oe_n` is 0 for WAIT_CYC cycles while `bus_oe` stays 0, and `mem_we_n` stays 1 for the whole read.
- R7: A read samples `bus_in` in its last cycle with `mem_oe_n` low. In the following cycle `rsp_valid` is 1 for exactly one cycle and `rsp_rdata` holds the sampled byte.
- R8: A write drives `bus_out` = write data with `bus_oe`=1 while `mem_we_n` is 0 for WAIT_CYC cycles, and for one more cycle after that with `mem_we_n`=1. `mem_oe_n` stays 1 and no `rsp_valid` is produced.
- R9: `mem_oe_n` and `mem_we_n` are never 0 together, and neither is 0 while an address strobe is 0.
- R10: A new request presented during the `rsp_valid` cycle of a read is accepted at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address in the external memory |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse when read data is available |
| rsp_rdata | output | 8 | Byte captured by the last read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_as0_n | output | 1 | Low-address latch strobe, active low |
| mem_as1_n | output | 1 | Mid-address latch strobe, active low |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | 1 when the block drives the shared bus |
| bus_in | input | 8 | Value read from the shared bus |

## Verification
A read's response pulse and the acceptance of the next request fall in the same cycle. The bench provokes this by holding the next request valid while the previous read is still in progress, so the handshake completes at the end of the cycle in which `rsp_valid` is high. A behavioural timeline model predicts that cycle. It is judged by comparing `rsp_rdata`, `req_ready` and the start of the new address phase cycle for cycle. The memory's reply changes on every cycle of the wait, so only a sample taken in the correct cycle matches.

// File: rtl/flash_mux_seq.sv
module flash_mux_seq #(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int WAIT_CYC   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [19:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata,
  output logic        mem_ce_n,
  output logic        mem_oe_n,
  output logic        mem_we_n,
  output logic        mem_as0_n,
  output logic        mem_as1_n,
  output logic [7:0]  bus_out,
  output logic        bus_oe,
  input  logic [7:0]  bus_in
);

  localparam int MAXC1 = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAXC2 = (HOLD_CYC > WAIT_CYC) ? HOLD_CYC : WAIT_CYC;
  localparam int MAXC  = (MAXC1 > MAXC2) ? MAXC1 : MAXC2;
  localparam int CW    = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] SET_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] STB_LAST = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] HLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] WT_LAST  = CW'(WAIT_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_TURN, S_RWAIT, S_WDRV, S_WHOLD} state_t;
  typedef enum logic [1:0] {PH_SET, PH_STB, PH_HLD} phase_t;

  state_t          state;
  phase_t          phase;
  logic [1:0]      slot;
  logic [CW-1:0]   cnt;
  logic [19:0]     addr_q;
  logic [7:0]      wdata_q;
  logic            write_q;
  logic [7:0]      addr_byte;

  always_comb begin
    case (slot)
      2'd0:    addr_byte = addr_q[7:0];
      2'd1:    addr_byte = addr_q[15:8];
      default: addr_byte = {4'b0000, addr_q[19:16]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase     <= PH_SET;
      slot      <= 2'd0;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            state   <= S_ADDR;
            phase   <= PH_SET;
            slot    <= 2'd0;
            cnt     <= '0;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
          end
        end
        S_ADDR: begin
          cnt <= cnt + 1'b1;
          case (phase)
            PH_SET: if (cnt == SET_LAST) begin phase <= PH_STB; cnt <= '0; end
            PH_STB: if (cnt == STB_LAST) begin phase <= PH_HLD; cnt <= '0; end
            default: if (cnt == HLD_LAST) begin
              cnt   <= '0;
              phase <= PH_SET;
              if (slot == 2'd2) state <= write_q ? S_WDRV : S_TURN;
              else              slot  <= slot + 2'd1;
            end
          endcase
        end
        S_TURN: begin
          state <= S_RWAIT;
          cnt   <= '0;
        end
        S_RWAIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == WT_LAST) begin
            rsp_rdata <= bus_in;
            rsp_valid <= 1'b1;
            state     <= S_IDLE;
          end
        end
        S_WDRV: begin
          cnt <= cnt + 1'b1;
          if (cnt == WT_LAST) state <= S_WHOLD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wire strobe_on = (state == S_ADDR) && (phase == PH_STB);

  assign req_ready = (state == S_IDLE);
  assign mem_ce_n  = (state == S_IDLE);
  assign mem_oe_n  = (state != S_RWAIT);
  assign mem_we_n  = (state != S_WDRV);
  assign mem_as0_n = !(strobe_on && slot != 2'd1);
  assign mem_as1_n = !(strobe_on && slot != 2'd0);
  assign bus_oe    = (state == S_ADDR) || (state == S_WDRV) || (state == S_WHOLD);
  assign bus_out   = (state == S_ADDR) ? addr_byte :
                     ((state == S_WDRV) || (state == S_WHOLD)) ? wdata_q : 8'h00;

  p_oe_we_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  p_enable_vs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_as0_n || !mem_as1_n) |-> (mem_oe_n && mem_we_n));
  p_ce_covers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n || !mem_as0_n || !mem_as1_n) |-> !mem_ce_n);
  p_strobe_stable_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_as0_n || !mem_as1_n) |-> (bus_oe && $stable(bus_out)));
  p_release_before_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (!bus_oe && $past(!bus_oe)));
  p_rsp_after_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n));
  p_accept_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (mem_ce_n && !bus_oe));
  p_write_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> bus_oe);

endmodule

// File: tb/tb_flash_mux_seq.sv
module tb_flash_mux_seq;
  localparam int S = 2, P = 1, H = 2, W = 3;
  localparam int L = S + P + H;
  localparam int T = 3 * L + W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, bus_in = 8'h5A;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_as0_n, mem_as1_n, bus_oe;
  logic [7:0] rsp_rdata, bus_out;

  always #5 clk = ~clk;

  flash_mux_seq #(.SETUP_CYC(S), .STROBE_CYC(P), .HOLD_CYC(H), .WAIT_CYC(W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_as0_n(mem_as0_n),
    .mem_as1_n(mem_as1_n), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in));

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0, m_seen_rst = 0, m_busy = 0, m_write = 0, m_rsp = 0, m_done = 0;
  int m_k = 0;
  logic [19:0] m_addr = '0;
  logic [7:0] m_wdata = '0, m_rdata = '0;
  logic [7:0] lat0 = '0, lat1 = '0, lat2 = '0;
  logic p_as0 = 1'b1, p_as1 = 1'b1;

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, got, exp);
    end
  endtask

  // behavioural timeline model
  always @(posedge clk) begin
    cyc++;
    m_rsp = 0;
    m_done = 0;
    if (!rst_n) begin
      m_seen_rst = 1; m_busy = 0; m_k = 0;
    end else if (m_busy) begin
      if (m_k == T - 1) begin
        m_busy = 0; m_done = 1;
        if (!m_write) begin
          m_rsp = 1;
          m_rdata = m_addr[7:0] ^ 8'(3 * L + W);
        end
      end else m_k++;
    end else if (req_valid) begin
      m_busy = 1; m_k = 0; m_write = req_write; m_addr = req_addr; m_wdata = req_wdata;
    end
  end

  // memory reply and per-cycle comparison
  always @(negedge clk) begin
    logic e_ce, e_oe, e_we, e_as0, e_as1, e_boe, stb;
    logic [7:0] e_bus;
    int b, r;
    e_ce = 1; e_oe = 1; e_we = 1; e_as0 = 1; e_as1 = 1; e_boe = 0; e_bus = 8'h00;
    if (m_busy) begin
      e_ce = 0;
      if (m_k < 3 * L) begin
        b = m_k / L; r = m_k % L;
        e_boe = 1;
        e_bus = (b == 0) ? m_addr[7:0] : (b == 1) ? m_addr[15:8] : {4'h0, m_addr[19:16]};
        stb = (r >= S) && (r < S + P);
        e_as0 = !(stb && b != 1);
        e_as1 = !(stb && b != 0);
      end else if (!m_write) begin
        e_oe = !(m_k >= 3 * L + 1);
      end else begin
        e_boe = 1; e_bus = m_wdata;
        e_we = !(m_k < 3 * L + W);
      end
    end
    bus_in = (m_busy && !m_write && !e_oe) ? (m_addr[7:0] ^ 8'(m_k)) : 8'h5A;
    if (m_seen_rst && !finished) begin
      chk("R2", "req_ready", req_ready, !m_busy);
      chk("R5", "mem_ce_n", mem_ce_n, e_ce);
      chk("R6", "mem_oe_n", mem_oe_n, e_oe);
      chk("R8", "mem_we_n", mem_we_n, e_we);
      chk("R4", "mem_as0_n", mem_as0_n, e_as0);
      chk("R4", "mem_as1_n", mem_as1_n, e_as1);
      chk("R3", "bus_oe", bus_oe, e_boe);
      if (e_boe) chk("R3", "bus_out", bus_out, e_bus);
      chk("R7", "rsp_valid", rsp_valid, m_rsp);
      if (m_rsp) chk("R7", "rsp_rdata", rsp_rdata, m_rdata);
      if (!m_busy && !m_rsp && !m_done)
        chk("R1", "idle pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_as0_n, mem_as1_n, bus_oe}, 6'b111110);
      // board latches: clock on rising strobe pattern
      if (!p_as0 && !p_as1 && mem_as0_n && mem_as1_n) lat2 = bus_out;
      else if (!p_as0 && p_as1 && mem_as0_n) lat0 = bus_out;
      else if (!p_as1 && p_as0 && mem_as1_n) lat1 = bus_out;
      if (m_done) chk("R4", "latched address", {lat2, lat1, lat0}, {4'h0, m_addr});
    end
    p_as0 = mem_as0_n; p_as1 = mem_as1_n;
  end

  task automatic issue(bit wr, logic [19:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic poke_busy(logic [19:0] a);
    repeat (4) begin
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = 8'hEE;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired: actual=%0d expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset pins", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_as0_n, mem_as1_n, bus_oe}, 7'b1111110);
    rst_n = 1;
    repeat (2) @(negedge clk);
    issue(0, 20'hA5C3E, 8'h00);              // R3 R6 R7 basic read
    issue(1, 20'h12345, 8'h3C);              // R8 write, R2 held until ready
    issue(0, 20'hFFFFF, 8'h00);              // R10: next issue lands in rsp cycle
    issue(0, 20'h00000, 8'h00);
    poke_busy(20'h0BEEF);                    // R2: ignored while busy
    repeat (3 * L + 6) @(negedge clk);
    issue(1, 20'hF0F0F, 8'hA5);
    poke_busy(20'h55555);
    issue(0, 20'h80001, 8'h00);
    repeat (T + 6) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule